// File: doc/BRIEF.md
# UART Register Front-End with Watermark Interrupts

This block is the host-facing register set of a simple serial port. A 32-bit word-wide register port lets software push bytes into an 8-entry transmit queue, pop bytes from an 8-entry receive queue, program two watermark counts, enable two interrupt sources and store a baud divisor. The bit-level shifter is not part of the block. The transmit queue drains onto a byte stream with a valid/ready handshake. The receive queue fills from a second byte stream with the same handshake.

The interrupt-pending bits are not latched events. They are recomputed every cycle by comparing queue occupancy against the programmed watermarks. The single interrupt line is the registered OR of the enabled pending bits. Draining starts only after a fixed number of cycles following a write that finds the transmit output idle. This emulates a short settling delay before characters leave.

Register offsets (byte addresses, word accesses only):

| Offset | Register |
|---|---|
| 0x00 | TX data |
| 0x04 | RX data |
| 0x08 | TX control |
| 0x0C | RX control |
| 0x10 | IE |
| 0x14 | IP (read-only) |
| 0x18 | divisor |

Top module: `uart_wm_regs`

## Requirements
- R1: After reset, TX control, RX control, IE, divisor and IP read 0, TX data reads 0, RX data reads 0x8000_0000, `irq` is 0, `tx_valid` is 0 and `rx_ready` is 1.
- R2: A read of RX data (0x04) with an empty receive queue returns 0x8000_0000 and leaves the queue and all pointers unchanged.
- R3: A read of RX data with a non-empty receive queue returns the oldest byte in bits 7:0 (upper bits 0) and removes it; bytes come out in arrival order.
- R4: A write to TX data (0x00) appends bits 7:0 to the transmit queue; a write that finds the queue full is discarded.
- R5: A read of TX data returns a full flag in bit 31 (other bits 0); it sets when the queue becomes full and clears after one entry has drained.
- R6: `rx_ready` is low while the receive queue holds 8 bytes, and a byte offered then is lost.
- R7: A write to TX data that finds `tx_valid` low keeps `tx_valid` low for START_DELAY cycles; `tx_valid` rises in the cycle after that, if the queue is non-empty.
- R8: IP bit 0 is 1 exactly when transmit occupancy is strictly less than TX control bits 18:16. IP bit 1 is 1 exactly when receive occupancy is strictly greater than RX control bits 18:16. Writes to IP have no effect.
- R9: `irq` equals the OR over both bits of (IE AND IP) from the previous cycle.
- R10: TX and RX control keep only bits 18:16, IE keeps bits 1:0, and the divisor keeps bits 15:0. All other bits read 0.
- R11: Bytes leave on `tx_data` in write order, and `tx_valid` with `tx_data` holds steady until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Byte address of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after a read |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Consumer accepts the outgoing byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the byte consumer only changes `tx_ready` between edges. They also assume that register accesses are single-cycle strobes with a stable address, so that a transmit write seen on one edge is the one that arms the start delay. The bench drives every input on the falling edge and pulses `req` for exactly one cycle per access. It holds `tx_ready` low while it sweeps the transmit occupancy, so that the watermark comparisons see a frozen queue. The receive stream is offered one byte per pulse, including one pulse while the queue is full.

// File: rtl/uart_wm_regs.sv
module uart_wm_regs #(
  parameter int DEPTH       = 8,
  parameter int START_DELAY = 5,
  parameter int DIV_W       = 16,
  parameter int WM_LSB      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [4:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic        irq
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int DLY_W = $clog2(START_DELAY + 1);
  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                         A_RXC = 5'h0C, A_IE  = 5'h10, A_IP  = 5'h14, A_DIV = 5'h18;
  localparam logic [31:0] EMPTY_WORD = 32'h8000_0000;

  logic [7:0]       tx_mem [DEPTH];
  logic [7:0]       rx_mem [DEPTH];
  logic [PTR_W-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [PTR_W-1:0] tx_wm, rx_wm;
  logic [1:0]       ie;
  logic [1:0]       ip;
  logic [DIV_W-1:0] div;
  logic             tx_full;
  logic [DLY_W-1:0] timer;
  logic [31:0]      rd_mux;

  wire wr_en   = req && we;
  wire rd_en   = req && !we;
  wire tx_wr   = wr_en && addr == A_TXD;
  wire tx_push = tx_wr && tx_cnt != CNT_W'(DEPTH);
  wire tx_pop  = tx_valid && tx_ready;
  wire rx_push = rx_valid && rx_ready;
  wire rx_pop  = rd_en && addr == A_RXD && rx_cnt != '0;

  assign rx_ready = rx_cnt != CNT_W'(DEPTH);
  assign tx_valid = timer == '0 && tx_cnt != '0;
  assign tx_data  = tx_mem[tx_rp];
  assign ip       = {rx_cnt > CNT_W'(rx_wm), tx_cnt < CNT_W'(tx_wm)};

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_full <= 1'b0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
      if (tx_push && !tx_pop && tx_cnt == CNT_W'(DEPTH - 1)) tx_full <= 1'b1;
      else if (tx_pop) tx_full <= 1'b0;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 timer <= '0;
    else if (tx_wr && !tx_valid) timer <= DLY_W'(START_DELAY);
    else if (timer != '0)        timer <= timer - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wm <= '0; rx_wm <= '0; ie <= '0; div <= '0;
    end else if (wr_en) begin
      case (addr)
        A_TXC:   tx_wm <= wdata[WM_LSB +: PTR_W];
        A_RXC:   rx_wm <= wdata[WM_LSB +: PTR_W];
        A_IE:    ie    <= wdata[1:0];
        A_DIV:   div   <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_TXD:   rd_mux = {tx_full, 31'b0};
      A_RXD:   rd_mux = (rx_cnt != '0) ? {24'b0, rx_mem[rx_rp]} : EMPTY_WORD;
      A_TXC:   rd_mux = 32'(tx_wm) << WM_LSB;
      A_RXC:   rd_mux = 32'(rx_wm) << WM_LSB;
      A_IE:    rd_mux = 32'(ie);
      A_IP:    rd_mux = 32'(ip);
      A_DIV:   rd_mux = 32'(div);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |(ie & ip);
    end
  end

  p_tx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH));
  p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH));
  p_full_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full == (tx_cnt == CNT_W'(DEPTH)));
  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_valid) |=> !tx_valid);
  p_empty_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RXD && rx_cnt == '0) |=> (rdata == EMPTY_WORD && $stable(rx_cnt)));
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> irq == $past(|(ie & ip)));
  p_tx_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/uart_wm_regs_tb_top.sv
module uart_wm_regs_tb_top;
  localparam int DEPTH = 8;
  localparam int DLY   = 5;
  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                         A_RXC = 5'h0C, A_IE  = 5'h10, A_IP  = 5'h14, A_DIV = 5'h18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  uart_wm_regs #(.DEPTH(DEPTH), .START_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [31:0] v;
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(irq == 0 && tx_valid == 0, "R1 irq/tx_valid", {irq, tx_valid}, 0);
    chk(rx_ready == 1, "R1 rx_ready", rx_ready, 1);
    rd(A_TXD, v); chk(v == 0, "R1 txdata", v, 0);
    rd(A_RXD, v); chk(v == 32'h8000_0000, "R1 rxdata", v, 32'h8000_0000);
    rd(A_TXC, v); chk(v == 0, "R1 txctrl", v, 0);
    rd(A_RXC, v); chk(v == 0, "R1 rxctrl", v, 0);
    rd(A_IE, v);  chk(v == 0, "R1 ie", v, 0);
    rd(A_IP, v);  chk(v == 0, "R1 ip", v, 0);
    rd(A_DIV, v); chk(v == 0, "R1 div", v, 0);

    // R10 field widths
    wr(A_TXC, 32'hFFFF_FFFF); rd(A_TXC, v); chk(v == 32'h0007_0000, "R10 txctrl", v, 32'h0007_0000);
    wr(A_RXC, 32'h0005_FFFF); rd(A_RXC, v); chk(v == 32'h0005_0000, "R10 rxctrl", v, 32'h0005_0000);
    wr(A_DIV, 32'hDEAD_BEEF); rd(A_DIV, v); chk(v == 32'h0000_BEEF, "R10 div", v, 32'h0000_BEEF);
    wr(A_IE, 32'hFFFF_FFFC);  rd(A_IE, v);  chk(v == 0, "R10 ie", v, 0);
    // R8 IP is read-only: tx wm 7, tx empty, rx wm 5, rx empty -> 0x1
    wr(A_IP, 32'hFFFF_FFFF);  rd(A_IP, v);  chk(v == 1, "R8 ip write ignored", v, 1);

    // R9 latency: ie bit0 with ip bit0 = 1
    wr(A_IE, 32'h1);
    chk(irq == 0, "R9 irq before", irq, 0);
    @(negedge clk); chk(irq == 1, "R9 irq after", irq, 1);
    wr(A_IE, 32'h0); @(negedge clk); chk(irq == 0, "R9 irq off", irq, 0);

    // R8/R5/R9 transmit sweep, consumer stalled
    wr(A_IE, 32'h1);
    for (int n = 0; n <= DEPTH; n++) begin
      for (int wm = 0; wm < 8; wm++) begin
        wr(A_TXC, 32'(wm) << 16);
        rd(A_IP, v);
        chk(v[0] == (n < wm), "R8 tx watermark", v[0], 32'(n < wm));
        chk(irq == (n < wm), "R9 irq tx", irq, 32'(n < wm));
      end
      rd(A_TXD, v);
      chk(v == ((n == DEPTH) ? 32'h8000_0000 : 0), "R5 full flag", v, (n == DEPTH) ? 32'h8000_0000 : 0);
      if (n < DEPTH) wr(A_TXD, 32'hFFFF_FF30 + 32'(n));
    end
    wr(A_IE, 32'h0);
    wr(A_TXD, 32'h0000_00AA); // R4 discarded while full
    chk(tx_valid == 1 && tx_data == 8'h30, "R11 head byte", tx_data, 8'h30);

    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    rd(A_TXD, v); chk(v == 0, "R5 flag clears after drain", v, 0);
    tx_ready = 1;
    got = 1;
    for (int c = 0; c < 20; c++) begin
      if (tx_valid) begin
        chk(tx_data == 8'h30 + 8'(got), "R11 order", tx_data, 8'h30 + 8'(got));
        got++;
      end
      @(negedge clk);
    end
    chk(got == DEPTH, "R4 full write dropped", got, DEPTH);

    // R7 start delay
    wr(A_TXD, 32'h0000_005A);
    for (int j = 0; j < DLY; j++) begin
      chk(tx_valid == 0, "R7 held low", tx_valid, 0);
      @(negedge clk);
    end
    chk(tx_valid == 1 && tx_data == 8'h5A, "R7 rises", {tx_valid, tx_data}, {1'b1, 8'h5A});
    @(negedge clk); tx_ready = 0;
    chk(tx_valid == 0, "R4 queue empty", tx_valid, 0);

    // R8/R6/R9 receive sweep
    wr(A_TXC, 32'h0);
    wr(A_IE, 32'h2);
    for (int n = 0; n <= DEPTH; n++) begin
      for (int wm = 0; wm < 8; wm++) begin
        wr(A_RXC, 32'(wm) << 16);
        rd(A_IP, v);
        chk(v[1] == (n > wm), "R8 rx watermark", v[1], 32'(n > wm));
        chk(irq == (n > wm), "R9 irq rx", irq, 32'(n > wm));
      end
      chk(rx_ready == (n < DEPTH), "R6 rx_ready", rx_ready, 32'(n < DEPTH));
      if (n < DEPTH) push(8'h50 + 8'(n));
    end
    push(8'hEE);
    chk(rx_ready == 0, "R6 still full", rx_ready, 0);
    wr(A_IE, 32'h0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, v);
      chk(v == 32'h50 + 32'(i), "R3 pop order", v, 32'h50 + 32'(i));
    end
    rd(A_RXD, v); chk(v == 32'h8000_0000, "R6 dropped byte absent", v, 32'h8000_0000);
    rd(A_RXD, v); chk(v == 32'h8000_0000, "R2 repeat empty", v, 32'h8000_0000);
    wr(A_RXC, 32'h0);
    rd(A_IP, v); chk(v[1] == 0, "R2 occupancy unchanged", v[1], 0);
    push(8'h77);
    rd(A_RXD, v); chk(v == 32'h77, "R2 pointers intact", v, 32'h77);
    chk(rx_ready == 1, "R3 room after pops", rx_ready, 1);

    summary();
  end
endmodule